// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

A purely combinational select generator that sits beside a microprocessor with a 20-bit byte address bus. From the address lines, the address strobe and the read and write cycle lines, it produces seven active-high select lines:

- one for a 256 KB RAM at the bottom of the one-megabyte space;
- one for a 256 KB ROM at the top of the space;
- one group select for a four-byte UART register window;
- one for each of the four UART registers.

Each select is its own Boolean function of the inputs, so a device sees its select for as long as the qualified cycle lasts.

A cycle counts as qualified only when the strobe is high and exactly one of read or write is high. The RAM answers to both directions. The ROM answers to reads only. The UART window is matched against every upper address bit, and the two lowest bits pick the register. Each register is selected only by a cycle in the direction it allows.

Top module: `addr_decoder`

## Requirements
- R1: While as_i is low, all seven select outputs are low, whatever the other inputs are.
- R2: ram_sel_o is high exactly when addr_i[19:18] = 2'b00 and the cycle is a qualified read or write.
- R3: rom_sel_o is high exactly when addr_i[19:18] = 2'b11 and the cycle is a qualified read. A write to that range raises no select.
- R4: uart_sel_o is high exactly when addr_i is in 0xBFFF0..0xBFFF3 and the cycle is a qualified read or write. Any UART register select implies uart_sel_o.
- R5: tx_data_sel_o is high only for a qualified write to 0xBFFF0. The register is write-only.
- R6: rx_data_sel_o is high only for a qualified read of 0xBFFF1. The register is read-only.
- R7: status_sel_o is high only for a qualified read of 0xBFFF2. The register is read-only.
- R8: ctrl_sel_o is high only for a qualified write to 0xBFFF3. The register is write-only.
- R9: When rd_i and wr_i are both high, or both low, all selects are low.
- R10: At most one of the six device selects is high at a time. uart_sel_o is not counted among the six.
- R11: Addresses 0x40000..0xBFFEF and 0xBFFF4..0xBFFFF raise no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Byte address, bit 19 most significant |
| as_i | input | 1 | Address strobe, high while the address is valid |
| rd_i | input | 1 | Read cycle indicator, active high |
| wr_i | input | 1 | Write cycle indicator, active high |
| ram_sel_o | output | 1 | RAM select |
| rom_sel_o | output | 1 | ROM select |
| uart_sel_o | output | 1 | UART register window select |
| tx_data_sel_o | output | 1 | Transmit data register select (write-only) |
| rx_data_sel_o | output | 1 | Receive data register select (read-only) |
| status_sel_o | output | 1 | Status register select (read-only) |
| ctrl_sel_o | output | 1 | Control register select (write-only) |

## Verification
The bench builds the decoder with its default parameters:

- a 20-bit bus;
- 256 KB memory spans;
- the register window at 0xBFFF0;
- write-only registers at indices 0 and 3.

At this size a random address almost never lands in the four-byte window. Part of the random stimulus is therefore drawn from 0xBFFE0..0xBFFFF, and the ends of every region are also driven directly. Together these cover each register in both directions, the bytes next to the window, and all eight combinations of the strobe, read and write lines.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int DEF_ADDR_W = 20;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_qual_t;
endpackage

// File: rtl/bus_qualifier.sv
module bus_qualifier
  import addr_dec_pkg::*;
(
  input  logic      as_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output bus_qual_t qual_o
);
  // exactly one direction, and only inside a strobed cycle
  always_comb begin
    qual_o.rd = as_i & rd_i & ~wr_i;
    qual_o.wr = as_i & wr_i & ~rd_i;
  end

  always_comb begin
    AST_QUAL_NEEDS_STROBE: assert (as_i || !(qual_o.rd || qual_o.wr)) else $error("qualified cycle without strobe"); // R1
    AST_QUAL_CONFLICT: assert ((rd_i != wr_i) || !(qual_o.rd || qual_o.wr)) else $error("ambiguous direction qualified"); // R9
  end
endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int                ADDR_W    = 20,
  parameter int                SPAN_LOG2 = 18,
  parameter logic [ADDR_W-1:0] BASE      = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - SPAN_LOG2;

  generate
    if (TAG_W > 0) begin : g_cmp
      assign hit_o = (addr_i[ADDR_W-1:SPAN_LOG2] == BASE[ADDR_W-1:SPAN_LOG2]);
    end else begin : g_all
      assign hit_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import addr_dec_pkg::*;
#(
  parameter int                  REG_LOG2 = 2,
  parameter int                  NUM_REG  = 2 ** REG_LOG2,
  parameter logic [NUM_REG-1:0]  WR_ONLY  = 4'b1001
) (
  input  logic                window_hit_i,
  input  logic [REG_LOG2-1:0] index_i,
  input  bus_qual_t           qual_i,
  output logic                group_sel_o,
  output logic [NUM_REG-1:0]  reg_sel_o
);
  assign group_sel_o = window_hit_i & (qual_i.rd | qual_i.wr);

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
      logic dir_ok;
      // write-only entries take writes, the rest take reads
      if (WR_ONLY[g]) begin : g_w
        assign dir_ok = qual_i.wr;
      end else begin : g_r
        assign dir_ok = qual_i.rd;
      end
      assign reg_sel_o[g] = window_hit_i & (index_i == REG_LOG2'(g)) & dir_ok;
    end
  endgenerate

  always_comb begin
    AST_REG_ONEHOT: assert ($onehot0(reg_sel_o)) else $error("multiple uart registers selected"); // R10
    AST_REG_IN_GROUP: assert (group_sel_o || (reg_sel_o == '0)) else $error("register select outside group"); // R4
  end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int                     ADDR_W        = DEF_ADDR_W,
  parameter int                     MEM_SPAN_LOG2 = 18,
  parameter logic [ADDR_W-1:0]      RAM_BASE      = 20'h00000,
  parameter logic [ADDR_W-1:0]      ROM_BASE      = 20'hC0000,
  parameter logic [ADDR_W-1:0]      UART_BASE     = 20'hBFFF0,
  parameter int                     UART_REG_LOG2 = 2,
  parameter logic [(2**UART_REG_LOG2)-1:0] UART_WR_ONLY = 4'b1001
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              ram_sel_o,
  output logic              rom_sel_o,
  output logic              uart_sel_o,
  output logic              tx_data_sel_o,
  output logic              rx_data_sel_o,
  output logic              status_sel_o,
  output logic              ctrl_sel_o
);
  localparam int UART_NREG = 2 ** UART_REG_LOG2;

  bus_qual_t             qual;
  logic                  ram_hit, rom_hit, uart_hit;
  logic [UART_NREG-1:0]  uart_reg_sel;

  bus_qualifier u_qual (
    .as_i   (as_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .qual_o (qual)
  );

  region_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(MEM_SPAN_LOG2), .BASE(RAM_BASE)) u_ram_hit (
    .addr_i (addr_i),
    .hit_o  (ram_hit)
  );

  region_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(MEM_SPAN_LOG2), .BASE(ROM_BASE)) u_rom_hit (
    .addr_i (addr_i),
    .hit_o  (rom_hit)
  );

  region_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(UART_REG_LOG2), .BASE(UART_BASE)) u_uart_hit (
    .addr_i (addr_i),
    .hit_o  (uart_hit)
  );

  uart_reg_decode #(.REG_LOG2(UART_REG_LOG2), .NUM_REG(UART_NREG), .WR_ONLY(UART_WR_ONLY)) u_uart_dec (
    .window_hit_i (uart_hit),
    .index_i      (addr_i[UART_REG_LOG2-1:0]),
    .qual_i       (qual),
    .group_sel_o  (uart_sel_o),
    .reg_sel_o    (uart_reg_sel)
  );

  assign ram_sel_o     = ram_hit & (qual.rd | qual.wr);
  assign rom_sel_o     = rom_hit & qual.rd;   // ROM ignores writes
  assign tx_data_sel_o = uart_reg_sel[0];
  assign rx_data_sel_o = uart_reg_sel[1];
  assign status_sel_o  = uart_reg_sel[2];
  assign ctrl_sel_o    = uart_reg_sel[3];

  logic [5:0] dev_sel;
  assign dev_sel = {ram_sel_o, rom_sel_o, tx_data_sel_o, rx_data_sel_o, status_sel_o, ctrl_sel_o};

  always_comb begin
    AST_NO_SEL_IDLE: assert (as_i || !(|dev_sel || uart_sel_o)) else $error("select without strobe"); // R1
    AST_ROM_READ_ONLY: assert (!rom_sel_o || (rd_i && !wr_i)) else $error("rom selected on non-read"); // R3
    AST_DIR_CONFLICT: assert ((rd_i != wr_i) || !(|dev_sel || uart_sel_o)) else $error("select on ambiguous cycle"); // R9
    AST_DEV_ONEHOT: assert ($onehot0(dev_sel)) else $error("more than one device selected"); // R10
    AST_TX_WRITE: assert (!tx_data_sel_o || wr_i) else $error("tx register selected on read"); // R5
    AST_RX_READ: assert (!rx_data_sel_o || rd_i) else $error("rx register selected on write"); // R6
    AST_STS_READ: assert (!status_sel_o || rd_i) else $error("status register selected on write"); // R7
    AST_CTL_WRITE: assert (!ctrl_sel_o || wr_i) else $error("control register selected on read"); // R8
  end
endmodule

// File: tb/sim_addr_decoder.sv
module sim_addr_decoder;
  logic        clk = 1'b0;
  logic [19:0] addr = '0;
  logic        as_s = 1'b0, rd_s = 1'b0, wr_s = 1'b0;
  logic ram_o, rom_o, uart_o, tx_o, rx_o, sts_o, ctl_o;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_decoder u0 (
    .addr_i(addr), .as_i(as_s), .rd_i(rd_s), .wr_i(wr_s),
    .ram_sel_o(ram_o), .rom_sel_o(rom_o), .uart_sel_o(uart_o),
    .tx_data_sel_o(tx_o), .rx_data_sel_o(rx_o), .status_sel_o(sts_o), .ctrl_sel_o(ctl_o)
  );

  // order: ram rom uart tx rx sts ctl (bit 6 .. bit 0)
  function automatic logic [6:0] model(logic [19:0] a, logic s, logic r, logic w);
    logic rq, wq, in_win;
    rq = s & r & ~w;
    wq = s & w & ~r;
    in_win = (a[19:2] == 18'h2FFFC);
    model[6] = (a[19:18] == 2'b00) & (rq | wq);
    model[5] = (a[19:18] == 2'b11) & rq;
    model[4] = in_win & (rq | wq);
    model[3] = in_win & (a[1:0] == 2'd0) & wq;
    model[2] = in_win & (a[1:0] == 2'd1) & rq;
    model[1] = in_win & (a[1:0] == 2'd2) & rq;
    model[0] = in_win & (a[1:0] == 2'd3) & wq;
  endfunction

  function automatic string tag_of(int b);
    case (b)
      6: tag_of = "R2 ram";   5: tag_of = "R3 rom";   4: tag_of = "R4 uart";
      3: tag_of = "R5 tx";    2: tag_of = "R6 rx";    1: tag_of = "R7 status";
      default: tag_of = "R8 ctrl";
    endcase
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%05h as=%b rd=%b wr=%b act=%b exp=%b", tag, addr, as_s, rd_s, wr_s, act, exp);
    end
  endtask

  // drive at posedge, sample at negedge; compare every output and onehot rule
  task automatic apply(logic [19:0] a, logic s, logic r, logic w, string ctx);
    logic [6:0] act, exp;
    @(posedge clk);
    addr = a; as_s = s; rd_s = r; wr_s = w;
    @(negedge clk);
    act = {ram_o, rom_o, uart_o, tx_o, rx_o, sts_o, ctl_o};
    exp = model(a, s, r, w);
    for (int b = 0; b < 7; b++) chk(tag_of(b), {6'b0, act[b]}, {6'b0, exp[b]});
    checks++;
    if ($countones({act[6:5], act[3:0]}) > 1) begin
      errors++;
      $display("FAIL R10 addr=%05h act=%b exp=at most one device", a, act);
    end
    if (ctx != "") chk(ctx, act, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%0d cycles exp=completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    @(negedge clk);
    chk("R1 reset idle", {ram_o, rom_o, uart_o, tx_o, rx_o, sts_o, ctl_o}, 7'b0);

    // R1: strobe low, every other combination
    for (int r = 0; r < 4; r++) begin
      apply(20'h00010, 1'b0, r[0], r[1], "R1 strobe low ram");
      apply(20'hBFFF0 + 20'(r), 1'b0, 1'b1, 1'b1, "R1 strobe low uart");
      apply(20'hBFFF0 + 20'(r), 1'b0, 1'b1, 1'b0, "R1 strobe low uart rd");
      apply(20'hBFFF0 + 20'(r), 1'b0, 1'b0, 1'b1, "R1 strobe low uart wr");
    end
    // R9: both or neither direction
    apply(20'h00000, 1'b1, 1'b1, 1'b1, "R9 both ram");
    apply(20'hFFFFF, 1'b1, 1'b0, 1'b0, "R9 none rom");
    apply(20'hBFFF1, 1'b1, 1'b1, 1'b1, "R9 both rx");
    // R2 / R3 boundaries
    apply(20'h00000, 1'b1, 1'b0, 1'b1, "R2 ram low wr");
    apply(20'h3FFFF, 1'b1, 1'b1, 1'b0, "R2 ram top rd");
    apply(20'h40000, 1'b1, 1'b1, 1'b0, "R11 above ram");
    apply(20'hC0000, 1'b1, 1'b1, 1'b0, "R3 rom low rd");
    apply(20'hFFFFF, 1'b1, 1'b0, 1'b1, "R3 rom write ignored");
    apply(20'hBFFFF, 1'b1, 1'b1, 1'b0, "R11 below rom");
    // UART registers in both directions, plus neighbours
    for (int i = 0; i < 4; i++) begin
      apply(20'hBFFF0 + 20'(i), 1'b1, 1'b1, 1'b0, "R4 uart read");
      apply(20'hBFFF0 + 20'(i), 1'b1, 1'b0, 1'b1, "R4 uart write");
    end
    apply(20'hBFFF0, 1'b1, 1'b0, 1'b1, "R5 tx write");
    apply(20'hBFFF0, 1'b1, 1'b1, 1'b0, "R5 tx read ignored");
    apply(20'hBFFF1, 1'b1, 1'b1, 1'b0, "R6 rx read");
    apply(20'hBFFF1, 1'b1, 1'b0, 1'b1, "R6 rx write ignored");
    apply(20'hBFFF2, 1'b1, 1'b1, 1'b0, "R7 status read");
    apply(20'hBFFF2, 1'b1, 1'b0, 1'b1, "R7 status write ignored");
    apply(20'hBFFF3, 1'b1, 1'b0, 1'b1, "R8 ctrl write");
    apply(20'hBFFF3, 1'b1, 1'b1, 1'b0, "R8 ctrl read ignored");
    apply(20'hBFFEF, 1'b1, 1'b1, 1'b0, "R11 below window");
    apply(20'hBFFF4, 1'b1, 1'b0, 1'b1, "R11 above window");
    apply(20'h7FFF1, 1'b1, 1'b1, 1'b0, "R11 alias of rx");

    // random mix, a quarter aimed at the register window
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] a;
      logic [2:0]  c;
      a = 20'($urandom);
      if (($urandom % 4) == 0) a = 20'hBFFE0 | 20'($urandom % 32);
      c = 3'($urandom);
      if (($urandom % 2) == 0) c = {1'b1, 1'b0, 1'b1} ^ {1'b0, 2'($urandom % 2) == 2'd0 ? 2'b11 : 2'b00};
      apply(a, c[2] | c[1] & c[0] ? c[2] : c[2], c[1], c[0], "");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule